// File: doc/BRIEF.md
# Ready-Warp Issue Scheduler

This block picks, on every clock cycle, one warp out of a pool of resident warp slots (48 by default, 32 threads each, 1,536 threads in all) and issues that warp's next instruction. A warp can be picked only when its slot is in use, it presents an instruction, it is not waiting on global memory, and none of the registers that instruction reads or writes is still pending in that warp's scoreboard. All per-warp state stays resident, so moving from one warp to another costs no cycle. A warp held up by a memory access of roughly 500 cycles is simply passed over while other warps keep the issue slot busy.

The front end presents, for each warp, the two source registers, the destination register and a load flag of the next instruction. The execution and memory units report register writebacks and memory completions. Slots are opened with a launch strobe and closed with an exit strobe. The issue decision is combinational on the current state and inputs. All state updates take effect at the next rising edge.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, every slot is free and `issueValid` is 0. The round-robin pointer resets to the last slot, so warp 0 has first priority.
- R2: A slot that was never launched, or has been exited, is never issued, even when its `instValid` bit is 1. A launched slot is issued only while its `instValid` bit is 1.
- R3: A warp is not issued while any one of its source A, source B or destination register is marked pending in that warp's own scoreboard.
- R4: Issuing a warp marks its destination register pending from the next cycle. A writeback naming that warp and register clears the mark from the next cycle. If a set and a clear hit the same bit in the same cycle, the set wins.
- R5: Issuing an instruction whose load flag is 1 sets the warp's memory-wait bit, and the warp is passed over until a memory completion names that warp. The warp becomes eligible in the cycle after the completion.
- R6: Among eligible warps, the first one in ascending index order starting just after the last issued warp is chosen. The search wraps from the highest slot back to slot 0.
- R7: In any cycle with at least one eligible warp, `issueValid` is 1 in that same cycle. Consecutive cycles may issue different warps with no idle cycle between them.
- R8: In a cycle with no eligible warp, `issueValid` is 0 and the round-robin pointer keeps its value.
- R9: A launch marks the slot in use and clears its scoreboard and memory-wait bit. A launch and an exit on the same slot in the same cycle resolve to the launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Open the slot named by launchWarp |
| launchWarp | input | 6 | Slot to open |
| exitValid | input | 1 | Close the slot named by exitWarp |
| exitWarp | input | 6 | Slot to close |
| instValid | input | 48 | Per warp: a next instruction is present |
| instSrcA | input | 48x4 | Per warp: first source register |
| instSrcB | input | 48x4 | Per warp: second source register |
| instDst | input | 48x4 | Per warp: destination register |
| instIsLoad | input | 48 | Per warp: next instruction is a global memory load |
| wbValid | input | 1 | A register writeback completed |
| wbWarp | input | 6 | Warp of the writeback |
| wbReg | input | 4 | Register of the writeback |
| memDoneValid | input | 1 | A memory access completed |
| memDoneWarp | input | 6 | Warp whose memory access completed |
| issueValid | output | 1 | An instruction is issued this cycle |
| issueWarp | output | 6 | Warp issued this cycle |

## Verification
A pending bit that stays set after its writeback shows up as `issueValid` low, or as another warp being chosen, in the very next cycle in which that warp presents an instruction. A pending bit that is never set shows up as a second issue of the same warp one cycle after the first. A pointer that drifts during idle cycles, or a memory-wait bit that clears too early or too late, changes the choice of warp in the first contested cycle that follows. Each of these appears at the ports within one or two cycles of the disturbance.

// File: rtl/wis_pkg.sv
package wis_pkg;
  parameter int unsigned WarpIdW = 6;
  parameter int unsigned RegIdW  = 4;
  localparam int unsigned NumRegs = 1 << RegIdW;

  typedef logic [WarpIdW-1:0] warpId_t;
  typedef logic [RegIdW-1:0]  regId_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic    fire;
    warpId_t warp;
  } issueStrobe_t;
endpackage

// File: rtl/wis_warp_slot.sv
module wis_warp_slot
  import wis_pkg::*;
#(
  parameter int unsigned REGS = NumRegs
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            launchHit,
  input  logic            exitHit,
  input  logic            issueHit,
  input  logic            issueLoad,
  input  logic            wbHit,
  input  regId_t          wbReg,
  input  logic            memDoneHit,
  input  logic            instValid,
  input  regId_t          srcA,
  input  regId_t          srcB,
  input  regId_t          dst,
  output logic            ready,
  output logic            slotValid,
  output logic            memWait,
  output logic [REGS-1:0] pendRow
);
  logic [REGS-1:0] pendNext;
  logic            hazard;

  always_comb begin
    pendNext = pendRow;
    if (wbHit)    pendNext[wbReg] = 1'b0;
    if (issueHit) pendNext[dst]   = 1'b1;  // set wins over clear
  end

  assign hazard = pendRow[srcA] | pendRow[srcB] | pendRow[dst];
  assign ready  = slotValid & instValid & ~memWait & ~hazard;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= 1'b0;
      memWait   <= 1'b0;
      pendRow   <= '0;
    end else if (launchHit) begin
      slotValid <= 1'b1;
      memWait   <= 1'b0;
      pendRow   <= '0;
    end else if (exitHit) begin
      slotValid <= 1'b0;
      memWait   <= 1'b0;
      pendRow   <= '0;
    end else begin
      pendRow <= pendNext;
      if (issueHit && issueLoad) memWait <= 1'b1;
      else if (memDoneHit)       memWait <= 1'b0;
    end
  end
endmodule

// File: rtl/wis_datapath.sv
module wis_datapath
  import wis_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 48,
  parameter int unsigned REGS      = NumRegs
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  issueStrobe_t                       strobe,
  input  logic                               launchValid,
  input  warpId_t                            launchWarp,
  input  logic                               exitValid,
  input  warpId_t                            exitWarp,
  input  logic [NUM_WARPS-1:0]               instValid,
  input  logic [NUM_WARPS-1:0][RegIdW-1:0]   instSrcA,
  input  logic [NUM_WARPS-1:0][RegIdW-1:0]   instSrcB,
  input  logic [NUM_WARPS-1:0][RegIdW-1:0]   instDst,
  input  logic [NUM_WARPS-1:0]               instIsLoad,
  input  logic                               wbValid,
  input  warpId_t                            wbWarp,
  input  regId_t                             wbReg,
  input  logic                               memDoneValid,
  input  warpId_t                            memDoneWarp,
  output logic [NUM_WARPS-1:0]               readyVec,
  output logic [NUM_WARPS-1:0]               slotValid,
  output logic [NUM_WARPS-1:0]               memWait,
  output logic [NUM_WARPS-1:0][REGS-1:0]     pendBoard
);
  logic issueLoad;
  assign issueLoad = strobe.fire & instIsLoad[strobe.warp];

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    localparam warpId_t SlotId = warpId_t'(w);
    wis_warp_slot #(.REGS(REGS)) u_slot (
      .clk        (clk),
      .rstN       (rstN),
      .launchHit  (launchValid  && (launchWarp  == SlotId)),
      .exitHit    (exitValid    && (exitWarp    == SlotId)),
      .issueHit   (strobe.fire  && (strobe.warp == SlotId)),
      .issueLoad  (issueLoad),
      .wbHit      (wbValid      && (wbWarp      == SlotId)),
      .wbReg      (wbReg),
      .memDoneHit (memDoneValid && (memDoneWarp == SlotId)),
      .instValid  (instValid[w]),
      .srcA       (instSrcA[w]),
      .srcB       (instSrcB[w]),
      .dst        (instDst[w]),
      .ready      (readyVec[w]),
      .slotValid  (slotValid[w]),
      .memWait    (memWait[w]),
      .pendRow    (pendBoard[w])
    );
  end
endmodule

// File: rtl/wis_control.sv
module wis_control
  import wis_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] readyVec,
  output issueStrobe_t         strobe,
  output warpId_t              rrPtr
);
  localparam warpId_t LastSlot = warpId_t'(NUM_WARPS - 1);

  logic    found;
  warpId_t pick;

  always_comb begin
    found = 1'b0;
    pick  = rrPtr;
    for (int off = 1; off <= int'(NUM_WARPS); off++) begin
      int idx;
      idx = (int'(rrPtr) + off) % int'(NUM_WARPS);
      if (!found && readyVec[idx]) begin
        found = 1'b1;
        pick  = warpId_t'(idx);
      end
    end
  end

  assign strobe.fire = found;
  assign strobe.warp = pick;

  always_ff @(posedge clk) begin
    if (!rstN)      rrPtr <= LastSlot;
    else if (found) rrPtr <= pick;
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 48
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             launchValid,
  input  logic [WarpIdW-1:0]               launchWarp,
  input  logic                             exitValid,
  input  logic [WarpIdW-1:0]               exitWarp,
  input  logic [NUM_WARPS-1:0]             instValid,
  input  logic [NUM_WARPS-1:0][RegIdW-1:0] instSrcA,
  input  logic [NUM_WARPS-1:0][RegIdW-1:0] instSrcB,
  input  logic [NUM_WARPS-1:0][RegIdW-1:0] instDst,
  input  logic [NUM_WARPS-1:0]             instIsLoad,
  input  logic                             wbValid,
  input  logic [WarpIdW-1:0]               wbWarp,
  input  logic [RegIdW-1:0]                wbReg,
  input  logic                             memDoneValid,
  input  logic [WarpIdW-1:0]               memDoneWarp,
  output logic                             issueValid,
  output logic [WarpIdW-1:0]               issueWarp
);
  issueStrobe_t                     strobe;
  warpId_t                          rrPtr;
  logic [NUM_WARPS-1:0]             readyVec;
  logic [NUM_WARPS-1:0]             slotValid;
  logic [NUM_WARPS-1:0]             memWait;
  logic [NUM_WARPS-1:0][NumRegs-1:0] pendBoard;

  wis_control #(.NUM_WARPS(NUM_WARPS)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .readyVec (readyVec),
    .strobe   (strobe),
    .rrPtr    (rrPtr)
  );

  wis_datapath #(.NUM_WARPS(NUM_WARPS), .REGS(NumRegs)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .launchValid  (launchValid),
    .launchWarp   (launchWarp),
    .exitValid    (exitValid),
    .exitWarp     (exitWarp),
    .instValid    (instValid),
    .instSrcA     (instSrcA),
    .instSrcB     (instSrcB),
    .instDst      (instDst),
    .instIsLoad   (instIsLoad),
    .wbValid      (wbValid),
    .wbWarp       (wbWarp),
    .wbReg        (wbReg),
    .memDoneValid (memDoneValid),
    .memDoneWarp  (memDoneWarp),
    .readyVec     (readyVec),
    .slotValid    (slotValid),
    .memWait      (memWait),
    .pendBoard    (pendBoard)
  );

  assign issueValid = strobe.fire;
  assign issueWarp  = strobe.warp;
endmodule

// File: rtl/wis_checker.sv
module wis_checker
  import wis_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 48
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              launchValid,
  input logic [WarpIdW-1:0]                launchWarp,
  input logic                              exitValid,
  input logic [WarpIdW-1:0]                exitWarp,
  input logic [NUM_WARPS-1:0]              instValid,
  input logic [NUM_WARPS-1:0][RegIdW-1:0]  instSrcA,
  input logic [NUM_WARPS-1:0][RegIdW-1:0]  instSrcB,
  input logic [NUM_WARPS-1:0][RegIdW-1:0]  instDst,
  input logic                              issueValid,
  input logic [WarpIdW-1:0]                issueWarp,
  input logic [NUM_WARPS-1:0]              readyVec,
  input logic [NUM_WARPS-1:0]              slotValid,
  input logic [NUM_WARPS-1:0]              memWait,
  input logic [NUM_WARPS-1:0][NumRegs-1:0] pendBoard
);
  AST_ISSUE_LIVE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (slotValid[issueWarp] && instValid[issueWarp])); // R2

  AST_NO_REG_HAZARD: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (!pendBoard[issueWarp][instSrcA[issueWarp]] &&
                    !pendBoard[issueWarp][instSrcB[issueWarp]] &&
                    !pendBoard[issueWarp][instDst[issueWarp]])); // R3

  AST_DST_MARKED: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !(launchValid && launchWarp == issueWarp) &&
                   !(exitValid && exitWarp == issueWarp))
    |=> pendBoard[$past(issueWarp)][$past(instDst[issueWarp])]); // R4

  AST_MEM_PASSED_OVER: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !memWait[issueWarp]); // R5

  AST_NO_IDLE_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    (|readyVec) |-> issueValid); // R7
endmodule

bind warp_issue_sched wis_checker #(.NUM_WARPS(NUM_WARPS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .launchValid (launchValid),
  .launchWarp  (launchWarp),
  .exitValid   (exitValid),
  .exitWarp    (exitWarp),
  .instValid   (instValid),
  .instSrcA    (instSrcA),
  .instSrcB    (instSrcB),
  .instDst     (instDst),
  .issueValid  (issueValid),
  .issueWarp   (issueWarp),
  .readyVec    (readyVec),
  .slotValid   (slotValid),
  .memWait     (memWait),
  .pendBoard   (pendBoard)
);

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;
  localparam int NW = 48;

  logic clk = 1'b0;
  logic rstN;
  logic launchValid, exitValid, wbValid, memDoneValid;
  logic [5:0] launchWarp, exitWarp, wbWarp, memDoneWarp;
  logic [3:0] wbReg;
  logic [NW-1:0] instValid, instIsLoad;
  logic [NW-1:0][3:0] instSrcA, instSrcB, instDst;
  logic issueValid;
  logic [5:0] issueWarp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    chk;
    bit    expV;
    int    expW;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  warp_issue_sched dut (
    .clk(clk), .rstN(rstN),
    .launchValid(launchValid), .launchWarp(launchWarp),
    .exitValid(exitValid), .exitWarp(exitWarp),
    .instValid(instValid), .instSrcA(instSrcA), .instSrcB(instSrcB),
    .instDst(instDst), .instIsLoad(instIsLoad),
    .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg),
    .memDoneValid(memDoneValid), .memDoneWarp(memDoneWarp),
    .issueValid(issueValid), .issueWarp(issueWarp)
  );

  // monitor: compares one cycle's expectation, 1 ns after the inputs settle
  always begin
    @(negedge clk);
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      if (e.chk) begin
        checks++;
        if (issueValid !== e.expV ||
            (e.expV && int'(issueWarp) != e.expW)) begin
          fails++;
          $display("FAIL %s: got valid=%0b warp=%0d, expected valid=%0b warp=%0d",
                   e.tag, issueValid, issueWarp, e.expV, e.expW);
        end
      end
    end
  end

  // driver: push the expectation for the current inputs, advance one cycle
  task automatic step(input bit ev, input int ew, input string tag);
    expItem_t e;
    e.chk = 1'b1; e.expV = ev; e.expW = ew; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    launchValid = 0; exitValid = 0; wbValid = 0; memDoneValid = 0;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 0, tag);
  endtask

  task automatic launch(input int w);
    launchValid = 1; launchWarp = 6'(w);
  endtask

  task automatic writeback(input int w, input int r);
    wbValid = 1; wbWarp = 6'(w); wbReg = 4'(r);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0;
    launchValid = 0; exitValid = 0; wbValid = 0; memDoneValid = 0;
    launchWarp = 0; exitWarp = 0; wbWarp = 0; memDoneWarp = 0; wbReg = 0;
    instValid = '0; instIsLoad = '0;
    for (int w = 0; w < NW; w++) begin
      instSrcA[w] = 4'd1; instSrcB[w] = 4'd2; instDst[w] = 4'd3;
    end
    @(negedge clk);
    instValid = '1;
    idle("R1 reset held");
    idle("R1 reset held");
    rstN = 1;
    idle("R1 after reset");
    idle("R2 no slot launched");
    instValid = '0;

    launch(0); idle("R2 launch cycle");
    launch(1); idle("R2 launch cycle");
    launch(2); idle("R2 launch cycle");

    instValid[0] = 1; instValid[1] = 1; instValid[2] = 1;
    step(1, 0, "R6 first pick after reset");
    step(1, 1, "R7 back-to-back switch");
    step(1, 2, "R7 back-to-back switch");
    writeback(1, 3);
    idle("R3 all destinations pending");
    step(1, 1, "R4 writeback clears pending");

    instValid = '0;
    writeback(0, 3); idle("R8 idle cycle");
    writeback(2, 3); idle("R8 idle cycle");
    writeback(1, 3); idle("R8 idle cycle");
    instValid[0] = 1; instValid[1] = 1; instValid[2] = 1;
    step(1, 2, "R8 pointer held through idle");
    step(1, 0, "R6 wrap to slot 0");
    step(1, 1, "R6 round-robin order");
    idle("R3 all destinations pending");

    instSrcA[0] = 4'd3; instDst[0] = 4'd5;
    writeback(1, 3);
    idle("R3 source A pending blocks");
    step(1, 1, "R3 other warp issues past hazard");

    instValid = '0;
    writeback(0, 3); idle("R8 idle");
    instSrcA[0] = 4'd1; instDst[0] = 4'd5; instIsLoad[0] = 1; instValid[0] = 1;
    step(1, 0, "R5 load issues");
    instIsLoad[0] = 0;
    writeback(0, 5);
    idle("R5 waiting on memory");
    for (int i = 0; i < 5; i++) idle("R5 waiting on memory");
    memDoneValid = 1; memDoneWarp = 6'd0;
    idle("R5 completion cycle still blocked");
    step(1, 0, "R5 eligible after completion");

    instValid = '0;
    writeback(0, 5); idle("R8 idle");
    writeback(1, 3); idle("R8 idle");
    exitValid = 1; exitWarp = 6'd1; idle("R2 exit cycle");
    instValid[1] = 1;
    idle("R2 exited slot ignored");
    instValid[1] = 0;

    launch(2); idle("R9 relaunch cycle");
    instValid[2] = 1;
    step(1, 2, "R9 launch cleared scoreboard");
    instValid = '0;

    launch(47); idle("R9 launch top slot");
    instValid[47] = 1;
    step(1, 47, "R6 highest slot");
    instValid[0] = 1;
    step(1, 0, "R6 wrap from highest slot");

    instValid = '0;
    instSrcB[0] = 4'd5; instDst[0] = 4'd6; instValid[0] = 1;
    idle("R3 source B pending blocks");

    instValid = '0;
    launch(3); exitValid = 1; exitWarp = 6'd3;
    idle("R9 launch and exit together");
    instValid[3] = 1;
    step(1, 3, "R9 launch wins over exit");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule